// File: doc/BRIEF.md
# Periodic Event Timer Channel

This block is a free-running event timer built around one 64-bit main counter and a single comparator channel. Software programs it through a small register interface: a read-only capability word, a general control word that starts or freezes the counter and selects legacy interrupt routing, a channel control word, the comparator and the main counter itself. Whenever the counter reaches the comparator value, the channel emits a one-clock interrupt pulse. Without legacy routing the pulse appears on the normal output. With legacy routing it appears on the legacy output.

In one-shot mode the comparator stays where software put it. In periodic mode the channel keeps a hidden period register that holds the most recent value written to the comparator, and it adds that period to the comparator on every match. A self-clearing set-value control lets software program a period while the counter is not at zero. With set-value armed, the first comparator write loads the absolute match point and the period. The second write changes only the hidden period, and that write disarms the control. A 32-bit mode restricts compare and reload to the low half of the counter.

Top module: `evt_timer`

## Requirements
- R1: While the run bit (bit 0 of the general control word, address 1) is 1, the main counter increases by one every clock. While it is 0, the counter holds its value.
- R2: A write to the main counter (address 4) takes effect only while the run bit is 0. While the counter runs, such a write is ignored and counting continues.
- R3: Register map: 0 = capability (read-only, bit 0 = 1 when legacy routing is supported), 1 = general control, 2 = channel control, 3 = comparator, 4 = main counter. A read presents its data on rdata one clock after rd_en. After reset every writable register reads 0 and both interrupt outputs are low.
- R4: With channel bits enable (bit 0) and periodic (bit 1) set, every match adds the hidden period to the comparator, so matches repeat at that spacing.
- R5: A comparator write made while set-value (channel bit 2) is clear loads the same value into both the comparator and the hidden period.
- R6: After set-value is armed, the first comparator write loads both the comparator and the period. The second write loads only the period and leaves the comparator unchanged. Set-value reads 1 until that second write and reads 0 afterwards.
- R7: In one-shot mode (periodic bit 0), a match produces one pulse and leaves the comparator unchanged.
- R8: A match while the counter runs produces a single pulse, one clock wide, in the clock after the counter equals the comparator. A match raises no pulse and causes no reload when channel enable is 0.
- R9: When legacy routing (general control bit 1, writable only if supported) is 1, the pulse appears on tmr_irq_legacy and tmr_irq stays low.
- R10: With the 32-bit bit (channel bit 3) set, comparator writes keep only their low 32 bits. Matching uses only the low 32 counter bits, and reload wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid one clock after rd_en |
| tmr_irq | output | 1 | Channel interrupt pulse, normal routing |
| tmr_irq_legacy | output | 1 | Channel interrupt pulse, legacy routing |

## Verification
A wrong comparator or hidden period in this block shows up at the ports as a pulse that lands at the wrong clock. The bench therefore records the exact cycle of every pulse and compares it with the arrival times computed from the programmed counter start, comparator and period. A set-value sequence that redirects the wrong write moves the second and third pulses by the period difference within about a dozen cycles. The bench also reads back the comparator after each run, so a reload on a disabled or one-shot channel is caught. For 32-bit mode, the bench starts the counter just below a low-half wrap, so a full-width compare or a full-width reload produces no pulse at all.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CAPS = 3'd0;
  localparam logic [ADDR_W-1:0] A_GEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHAN = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  // channel control word, bit 0 is enable
  typedef struct packed {
    logic w32;
    logic setval;
    logic periodic;
    logic enable;
  } chcfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_i | wr_i;
    cnt_n  = cnt_q;
    if (wr_i && !run_i) cnt_n = wdata_i;
    else if (run_i)     cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_i) |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output chcfg_t           cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o
);
  localparam int PAD_W = CNT_W - NARROW_W;

  chcfg_t           cfg_q, cfg_n;
  logic [CNT_W-1:0] cmp_q, cmp_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic             phase_q, phase_n;
  logic             fire_q;
  logic             eq, match;

  function automatic logic [CNT_W-1:0] fold(input logic [CNT_W-1:0] v, input logic narrow);
    fold = narrow ? {{PAD_W{1'b0}}, v[NARROW_W-1:0]} : v;
  endfunction

  always_comb begin
    eq    = cfg_q.w32 ? (cnt_i[NARROW_W-1:0] == cmp_q[NARROW_W-1:0]) : (cnt_i == cmp_q);
    match = run_i && cfg_q.enable && eq;
  end

  always_comb begin
    cfg_n   = cfg_q;
    cmp_n   = cmp_q;
    per_n   = per_q;
    phase_n = phase_q;
    if (match && cfg_q.periodic) cmp_n = fold(cmp_q + per_q, cfg_q.w32);
    if (cfg_we_i) begin
      cfg_n   = chcfg_t'(cfg_wdata_i);
      phase_n = 1'b0;
    end
    if (cmp_we_i) begin
      if (cfg_q.setval && phase_q) begin
        per_n        = fold(cmp_wdata_i, cfg_q.w32);
        cfg_n.setval = 1'b0;
        phase_n      = 1'b0;
      end else begin
        cmp_n = fold(cmp_wdata_i, cfg_q.w32);
        per_n = fold(cmp_wdata_i, cfg_q.w32);
        if (cfg_q.setval) phase_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cmp_q   <= '0;
      per_q   <= '0;
      phase_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_n;
      cmp_q   <= cmp_n;
      per_q   <= per_n;
      phase_q <= phase_n;
      fire_q  <= match;
    end
  end

  assign cfg_o  = cfg_q;
  assign cmp_o  = cmp_q;
  assign fire_o = fire_q;

  AST_SETVAL_HOLDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && cfg_q.setval && phase_q) |=> ($stable(cmp_q) && !cfg_q.setval)); // R6
  AST_ONESHOT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.periodic && !cmp_we_i) |=> $stable(cmp_q)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.enable && !cmp_we_i) |=> ($stable(cmp_q) && !fire_q)); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q); // R8
  AST_NARROW_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.w32 |=> (cfg_q.w32 |-> (cmp_q[CNT_W-1:NARROW_W] == '0 || $past(cmp_q[CNT_W-1:NARROW_W]) == cmp_q[CNT_W-1:NARROW_W]))); // R10
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int   CNT_W   = 64,
  parameter logic LEG_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        gen_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  chcfg_t            chcfg_i,
  output logic              run_o,
  output logic              leg_o,
  output logic              cnt_we_o,
  output logic              cfg_we_o,
  output logic              cmp_we_o,
  output logic [CNT_W-1:0]  rdata_o
);
  logic             run_q, run_n, leg_q, leg_n, gen_we;
  logic [CNT_W-1:0] rd_q, rd_n;

  always_comb begin
    gen_we   = wr_en && (addr == A_GEN);
    cnt_we_o = wr_en && (addr == A_CNT);
    cfg_we_o = wr_en && (addr == A_CHAN);
    cmp_we_o = wr_en && (addr == A_CMP);
    run_n    = gen_wdata[0];
    leg_n    = gen_wdata[1] & LEG_CAP;
  end

  always_comb begin
    rd_n = '0;
    unique case (addr)
      A_CAPS:  rd_n[0]   = LEG_CAP;
      A_GEN:   rd_n[1:0] = {leg_q, run_q};
      A_CHAN:  rd_n[3:0] = chcfg_i;
      A_CMP:   rd_n      = cmp_i;
      A_CNT:   rd_n      = cnt_i;
      default: rd_n      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (gen_we) begin
      run_q <= run_n;
      leg_q <= leg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_n;
  end

  assign run_o   = run_q;
  assign leg_o   = leg_q;
  assign rdata_o = rd_q;

  AST_LEG_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    leg_q |-> LEG_CAP); // R9
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int   CNT_W    = 64,
  parameter int   NARROW_W = 32,
  parameter logic LEG_CAP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              tmr_irq,
  output logic              tmr_irq_legacy
);
  logic             run, leg, cnt_we, cfg_we, cmp_we, fire;
  logic [CNT_W-1:0] cnt, cmp;
  chcfg_t           chcfg;

  evt_regs #(.CNT_W(CNT_W), .LEG_CAP(LEG_CAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .gen_wdata(wdata[1:0]), .cnt_i(cnt), .cmp_i(cmp), .chcfg_i(chcfg),
    .run_o(run), .leg_o(leg), .cnt_we_o(cnt_we), .cfg_we_o(cfg_we),
    .cmp_we_o(cmp_we), .rdata_o(rdata)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .wr_i(cnt_we),
    .wdata_i(wdata), .cnt_o(cnt)
  );

  evt_channel #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .cnt_i(cnt),
    .cfg_we_i(cfg_we), .cfg_wdata_i(wdata[3:0]), .cmp_we_i(cmp_we),
    .cmp_wdata_i(wdata), .cfg_o(chcfg), .cmp_o(cmp), .fire_o(fire)
  );

  assign tmr_irq        = fire & ~leg;
  assign tmr_irq_legacy = fire & leg;

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_irq, tmr_irq_legacy})); // R9
  AST_IRQ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq || tmr_irq_legacy) |-> $past(run)); // R8
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
  localparam logic [2:0] A_CAPS = 3'd0, A_GEN = 3'd1, A_CHAN = 3'd2, A_CMP = 3'd3, A_CNT = 3'd4;
  localparam int NV = 6;
  // {addr, write data, expected readback}
  localparam logic [130:0] VEC [NV] = '{
    {A_CNT,  64'h0000_0001_2345_6789, 64'h0000_0001_2345_6789},
    {A_CMP,  64'h0000_00AB_CDEF_0123, 64'h0000_00AB_CDEF_0123},
    {A_CHAN, 64'h3,                   64'h3},
    {A_GEN,  64'h2,                   64'h2},
    {A_GEN,  64'h0,                   64'h0},
    {A_CHAN, 64'h0,                   64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [2:0]  addr;
  logic [63:0] wdata, rdata;
  logic        tmr_irq, tmr_irq_legacy;
  int n_run = 0, n_fail = 0;
  int pm_n, pl_n;
  int pm_at [8];
  int pl_at [8];

  always #2.5 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_irq(tmr_irq), .tmr_irq_legacy(tmr_irq_legacy)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic watch(input int n);
    pm_n = 0; pl_n = 0;
    for (int i = 0; i < 8; i++) begin pm_at[i] = 0; pl_at[i] = 0; end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tmr_irq)        begin if (pm_n < 8) pm_at[pm_n] = k; pm_n++; end
      if (tmr_irq_legacy) begin if (pl_n < 8) pl_at[pl_n] = k; pl_n++; end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R3
    check("R3 irq at reset", {62'd0, tmr_irq, tmr_irq_legacy}, 64'd0);
    rd(A_CAPS, v); check("R3 capability", v, 64'd1);
    rd(A_GEN, v);  check("R3 general reset", v, 64'd0);
    rd(A_CHAN, v); check("R3 channel reset", v, 64'd0);
    rd(A_CMP, v);  check("R3 comparator reset", v, 64'd0);
    rd(A_CNT, v);  check("R3 counter reset", v, 64'd0);

    // vector walk: write then read back, R3 R5 R9
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][130:128], VEC[i][127:64]);
      rd(VEC[i][130:128], v);
      check("R3 vector readback", v, VEC[i][63:0]);
    end

    // R1 frozen counter
    wr(A_CNT, 64'd5);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R1 counter frozen", v, 64'd5);

    // R1 counting: run edge plus 7 cycles, stop edge counts too
    wr(A_CNT, 64'd0); wr(A_GEN, 64'd1);
    repeat (7) @(negedge clk);
    wr(A_GEN, 64'd0);
    rd(A_CNT, v); check("R1 counter step", v, 64'd8);

    // R2 counter write ignored while running
    wr(A_CNT, 64'd0); wr(A_GEN, 64'd1);
    repeat (3) @(negedge clk);
    wr(A_CNT, 64'd777); wr(A_GEN, 64'd0);
    rd(A_CNT, v); check("R2 write ignored while running", v, 64'd5);

    // R4 R5 R8 periodic, normal comparator write
    wr(A_CNT, 64'd0); wr(A_CMP, 64'd10); wr(A_CHAN, 64'h3); wr(A_GEN, 64'd1);
    watch(35);
    wr(A_GEN, 64'd0);
    check("R4 pulse count", pm_n, 64'd3);
    check("R8 first pulse one cycle after match", pm_at[0], 64'd11);
    check("R5 period from normal write", pm_at[1], 64'd21);
    check("R4 third pulse", pm_at[2], 64'd31);
    check("R9 no legacy pulse", pl_n, 64'd0);
    rd(A_CMP, v); check("R4 comparator advanced", v, 64'd40);

    // R6 set-value sequence with counter away from zero
    wr(A_CNT, 64'd100); wr(A_CHAN, 64'h7); wr(A_CMP, 64'd105);
    rd(A_CHAN, v); check("R6 set-value armed after first write", v, 64'h7);
    wr(A_CMP, 64'd7);
    rd(A_CHAN, v); check("R6 set-value self-cleared", v, 64'h3);
    rd(A_CMP, v);  check("R6 second write kept comparator", v, 64'd105);
    wr(A_GEN, 64'd1);
    watch(20);
    wr(A_GEN, 64'd0);
    check("R6 pulse count", pm_n, 64'd3);
    check("R6 first match", pm_at[0], 64'd6);
    check("R6 hidden period used", pm_at[1], 64'd13);
    check("R6 third match", pm_at[2], 64'd20);

    // R8 channel disabled
    wr(A_CNT, 64'd0); wr(A_CHAN, 64'h2); wr(A_CMP, 64'd5); wr(A_GEN, 64'd1);
    watch(20);
    wr(A_GEN, 64'd0);
    check("R8 disabled no pulse", pm_n + pl_n, 64'd0);
    rd(A_CMP, v); check("R8 disabled no reload", v, 64'd5);

    // R7 one-shot with R9 legacy routing
    wr(A_CNT, 64'd0); wr(A_CHAN, 64'h1); wr(A_CMP, 64'd5); wr(A_GEN, 64'd3);
    watch(20);
    wr(A_GEN, 64'd0);
    check("R9 legacy pulse count", pl_n, 64'd1);
    check("R9 legacy pulse time", pl_at[0], 64'd6);
    check("R9 normal output quiet", pm_n, 64'd0);
    rd(A_CMP, v); check("R7 one-shot comparator kept", v, 64'd5);

    // R10 32-bit mode across a low-half wrap
    wr(A_CNT, 64'h0000_0005_FFFF_FFF0); wr(A_CHAN, 64'hF);
    wr(A_CMP, 64'hDEAD_0000_FFFF_FFFA); wr(A_CMP, 64'd8);
    rd(A_CMP, v); check("R10 comparator truncated", v, 64'h0000_0000_FFFF_FFFA);
    wr(A_GEN, 64'd1);
    watch(22);
    wr(A_GEN, 64'd0);
    check("R10 pulse count", pm_n, 64'd2);
    check("R10 low-half match", pm_at[0], 64'd11);
    check("R10 wrapped reload match", pm_at[1], 64'd19);
    rd(A_CMP, v); check("R10 reload modulo 2^32", v, 64'h0000_0000_0000_000A);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule